// File: doc/BRIEF.md
# Decimal-capable add/subtract unit

This unit is the arithmetic core used for add-with-carry and subtract-with-borrow in an accumulator-style processor. It combines the accumulator value with a memory operand and an incoming carry. The result is computed either as a plain binary number or as packed BCD, where each 4-bit nibble holds one decimal digit. A decimal-mode input selects the path. The binary and decimal paths are built side by side, and a multiplexer picks one of them. Both paths feed a common flag generator that produces carry, zero, negative and overflow.

The operation is captured in a registered output stage. The registered result is the value written back to the accumulator, and `res_valid` marks the cycle in which that write happens. When no operation is presented, the outputs keep their last values. The digit count is a parameter. With the default of two digits the unit is 8 bits wide. Inputs whose decimal digits are above nine are outside the intended use.

Top module: `bcd_addsub_unit`

## Requirements
- R1: Binary add (op_sub=0, dec_mode=0): res_out = (acc_in + mem_in + carry_in) mod 256, and flag_c = 1 exactly when that unreduced sum is above 255.
- R2: Binary subtract (op_sub=1, dec_mode=0): res_out = (acc_in - mem_in - 1 + carry_in) mod 256, and flag_c = 1 exactly when acc_in >= mem_in + (1 - carry_in) as unsigned numbers. carry_in = 1 means no borrow.
- R3: Decimal add (op_sub=0, dec_mode=1), low digit (bits 3:0): L = acc_lo + mem_lo + carry_in. When L >= 10, the result digit is L - 10 and one is carried into the high digit. Otherwise the result digit is L.
- R4: Decimal add, high digit (bits 7:4): H = acc_hi + mem_hi + low carry. When H >= 10, the result digit is H - 10 and flag_c = 1. Otherwise the result digit is H and flag_c = 0. For valid digit inputs, every result digit is at most 9.
- R5: Decimal subtract (op_sub=1, dec_mode=1), low digit: L = acc_lo - mem_lo - 1 + carry_in. When L < 0, the result digit is L + 10 and one is borrowed from the high digit.
- R6: Decimal subtract, high digit: H = acc_hi - mem_hi - low borrow. When H < 0, the result digit is H + 10 and flag_c = 0. Otherwise the result digit is H and flag_c = 1.
- R7: In both modes, flag_z = 1 exactly when res_out is 0x00, and flag_n equals res_out bit 7.
- R8: For addition in both modes, flag_v = 1 exactly when acc_in bit 7 equals mem_in bit 7 and res_out bit 7 differs from acc_in bit 7.
- R9: For subtraction in both modes, flag_v = 1 exactly when acc_in bit 7 differs from mem_in bit 7 and res_out bit 7 differs from acc_in bit 7.
- R10: The result and flags of an operation presented with op_valid=1 at a rising edge appear on the outputs right after that edge. res_valid is 1 in the cycle after op_valid was 1, and 0 in the cycle after op_valid was 0.
- R11: While op_valid = 0, res_out and the four flags keep their values, whatever the other inputs do.
- R12: While rst_n = 0, res_out, all flags and res_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; asserted asynchronously, released synchronously |
| op_valid | input | 1 | Operation present in this cycle |
| op_sub | input | 1 | 1 = subtract with borrow, 0 = add with carry |
| dec_mode | input | 1 | 1 = packed-BCD arithmetic, 0 = binary |
| carry_in | input | 1 | Carry status bit going into the operation |
| acc_in | input | 8 | Accumulator operand |
| mem_in | input | 8 | Memory operand |
| res_out | output | 8 | Registered result, the value written back to the accumulator |
| flag_c | output | 1 | Carry out (for subtract: no borrow) |
| flag_z | output | 1 | Result is zero |
| flag_n | output | 1 | Result bit 7 |
| flag_v | output | 1 | Signed overflow |
| res_valid | output | 1 | Outputs were updated by the previous operation |

## Verification
Directed vectors place each decimal digit just below, at and across the ten boundary, in both directions. This separates a digit that needs adjusting from one that does not. It also separates a carry or borrow that stays inside the byte from one that leaves it, as in 0x99 + 0x01 and 0x00 - 0x01. Binary vectors cover wrap to zero, signed overflow in each direction, and equal operands with both carry-in values, so a missing or inverted borrow shows up in C and Z. Long back-to-back runs of random operations, with valid decimal digits and a random mode, check results against the scoreboard. Idle cycles with changing inputs show that the registered outputs are held.

// File: rtl/bcd_addsub_pkg.sv
package bcd_addsub_pkg;

  localparam int BCD_DIGIT_W = 4;
  localparam int BCD_RADIX   = 10;

  typedef struct packed {
    logic c;
    logic z;
    logic n;
    logic v;
  } alu_flags_t;

endpackage

// File: rtl/bcd_digit_cell.sv
module bcd_digit_cell #(
  parameter int DW    = 4,
  parameter int RADIX = 10
) (
  input  logic [DW-1:0] a_dig,
  input  logic [DW-1:0] m_dig,
  input  logic          op_sub,
  input  logic          chain_in,
  output logic [DW-1:0] dig_out,
  output logic          chain_out
);

  localparam int RW = DW + 2;
  localparam logic [RW-1:0] RADIX_V = RW'(RADIX);

  logic [RW-1:0] add_raw;
  logic [RW-1:0] sub_raw;
  logic [RW-1:0] add_adj;
  logic [RW-1:0] sub_adj;

  always_comb begin
    add_raw = {2'b00, a_dig} + {2'b00, m_dig} + {{(RW-1){1'b0}}, chain_in};
    sub_raw = {2'b00, a_dig} - {2'b00, m_dig} - {{(RW-1){1'b0}}, chain_in};
    add_adj = add_raw - RADIX_V;
    sub_adj = sub_raw + RADIX_V;
    if (op_sub) begin
      chain_out = sub_raw[RW-1];
      dig_out   = chain_out ? sub_adj[DW-1:0] : sub_raw[DW-1:0];
    end else begin
      chain_out = (add_raw >= RADIX_V);
      dig_out   = chain_out ? add_adj[DW-1:0] : add_raw[DW-1:0];
    end
  end

endmodule

// File: rtl/bcd_dec_path.sv
module bcd_dec_path #(
  parameter int DIGITS = 2,
  parameter int DW     = 4,
  parameter int RADIX  = 10
) (
  input  logic [DIGITS*DW-1:0] a_val,
  input  logic [DIGITS*DW-1:0] m_val,
  input  logic                 op_sub,
  input  logic                 carry_in,
  output logic [DIGITS*DW-1:0] res_val,
  output logic                 carry_out
);

  logic [DIGITS:0] chain;

  assign chain[0] = op_sub ? ~carry_in : carry_in;

  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    bcd_digit_cell #(
      .DW   (DW),
      .RADIX(RADIX)
    ) u_cell (
      .a_dig    (a_val[g*DW +: DW]),
      .m_dig    (m_val[g*DW +: DW]),
      .op_sub   (op_sub),
      .chain_in (chain[g]),
      .dig_out  (res_val[g*DW +: DW]),
      .chain_out(chain[g+1])
    );
  end

  assign carry_out = op_sub ? ~chain[DIGITS] : chain[DIGITS];

endmodule

// File: rtl/bcd_bin_path.sv
module bcd_bin_path #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_val,
  input  logic [WIDTH-1:0] m_val,
  input  logic             op_sub,
  input  logic             carry_in,
  output logic [WIDTH-1:0] res_val,
  output logic             carry_out
);

  logic [WIDTH-1:0] m_eff;

  assign m_eff = op_sub ? ~m_val : m_val;
  assign {carry_out, res_val} = {1'b0, a_val} + {1'b0, m_eff}
                              + {{WIDTH{1'b0}}, carry_in};

endmodule

// File: rtl/bcd_flag_gen.sv
module bcd_flag_gen
  import bcd_addsub_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_val,
  input  logic [WIDTH-1:0] m_val,
  input  logic [WIDTH-1:0] res_val,
  input  logic             op_sub,
  input  logic             carry,
  output alu_flags_t       flags
);

  localparam int MSB = WIDTH - 1;

  logic sign_ops_differ;
  logic sign_res_moved;

  always_comb begin
    sign_ops_differ = a_val[MSB] ^ m_val[MSB];
    sign_res_moved  = a_val[MSB] ^ res_val[MSB];
    flags.c = carry;
    flags.z = (res_val == '0);
    flags.n = res_val[MSB];
    flags.v = op_sub ? (sign_ops_differ & sign_res_moved)
                     : (~sign_ops_differ & sign_res_moved);
  end

endmodule

// File: rtl/bcd_addsub_unit.sv
module bcd_addsub_unit
  import bcd_addsub_pkg::*;
#(
  parameter int DIGITS  = 2,
  parameter int DIGIT_W = BCD_DIGIT_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        op_valid,
  input  logic                        op_sub,
  input  logic                        dec_mode,
  input  logic                        carry_in,
  input  logic [DIGITS*DIGIT_W-1:0]   acc_in,
  input  logic [DIGITS*DIGIT_W-1:0]   mem_in,
  output logic [DIGITS*DIGIT_W-1:0]   res_out,
  output logic                        flag_c,
  output logic                        flag_z,
  output logic                        flag_n,
  output logic                        flag_v,
  output logic                        res_valid
);

  localparam int WIDTH = DIGITS * DIGIT_W;

  logic [WIDTH-1:0] bin_res;
  logic             bin_carry;
  logic [WIDTH-1:0] dec_res;
  logic             dec_carry;
  logic [WIDTH-1:0] sel_res;
  logic             sel_carry;
  alu_flags_t       flags_comb;

  logic [WIDTH-1:0] res_q,   res_d;
  alu_flags_t       flags_q, flags_d;
  logic             vld_q,   vld_d;

  bcd_bin_path #(.WIDTH(WIDTH)) u_bin (
    .a_val    (acc_in),
    .m_val    (mem_in),
    .op_sub   (op_sub),
    .carry_in (carry_in),
    .res_val  (bin_res),
    .carry_out(bin_carry)
  );

  bcd_dec_path #(
    .DIGITS(DIGITS),
    .DW    (DIGIT_W),
    .RADIX (BCD_RADIX)
  ) u_dec (
    .a_val    (acc_in),
    .m_val    (mem_in),
    .op_sub   (op_sub),
    .carry_in (carry_in),
    .res_val  (dec_res),
    .carry_out(dec_carry)
  );

  always_comb begin
    sel_res   = dec_mode ? dec_res   : bin_res;
    sel_carry = dec_mode ? dec_carry : bin_carry;
  end

  bcd_flag_gen #(.WIDTH(WIDTH)) u_flags (
    .a_val  (acc_in),
    .m_val  (mem_in),
    .res_val(sel_res),
    .op_sub (op_sub),
    .carry  (sel_carry),
    .flags  (flags_comb)
  );

  // next-state: load on a valid operation, otherwise hold
  always_comb begin
    res_d   = res_q;
    flags_d = flags_q;
    vld_d   = op_valid;
    if (op_valid) begin
      res_d   = sel_res;
      flags_d = flags_comb;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q   <= '0;
      flags_q <= '0;
      vld_q   <= 1'b0;
    end else begin
      res_q   <= res_d;
      flags_q <= flags_d;
      vld_q   <= vld_d;
    end
  end

  assign res_out   = res_q;
  assign flag_c    = flags_q.c;
  assign flag_z    = flags_q.z;
  assign flag_n    = flags_q.n;
  assign flag_v    = flags_q.v;
  assign res_valid = vld_q;

  // digit validity, used only by the range check below
  logic [DIGITS-1:0] acc_dig_ok, mem_dig_ok, res_dig_ok;
  for (genvar g = 0; g < DIGITS; g++) begin : g_dig_ok
    assign acc_dig_ok[g] = (acc_in[g*DIGIT_W +: DIGIT_W]  < DIGIT_W'(BCD_RADIX));
    assign mem_dig_ok[g] = (mem_in[g*DIGIT_W +: DIGIT_W]  < DIGIT_W'(BCD_RADIX));
    assign res_dig_ok[g] = (res_out[g*DIGIT_W +: DIGIT_W] < DIGIT_W'(BCD_RADIX));
  end

  assert_valid_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> res_valid);

  assert_idle_no_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> !res_valid);

  assert_hold_outputs_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> ($stable(res_out) && $stable(flag_c) && $stable(flag_z)
                   && $stable(flag_n) && $stable(flag_v)));

  assert_zero_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (flag_z == (res_out == '0)));

  assert_neg_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (flag_n == res_out[WIDTH-1]));

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !op_sub && (acc_in[WIDTH-1] != mem_in[WIDTH-1])) |=> !flag_v);

  assert_equal_sub_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sub && !dec_mode && carry_in && (acc_in == mem_in))
      |=> (flag_c && flag_z));

  assert_dec_digit_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && dec_mode && (&acc_dig_ok) && (&mem_dig_ok)) |=> (&res_dig_ok));

endmodule

// File: tb/sim_bcd_addsub_unit.sv
`timescale 1ns/1ps
module sim_bcd_addsub_unit;

  typedef struct packed {
    logic [7:0] r;
    logic       c;
    logic       z;
    logic       n;
    logic       v;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       op_valid, op_sub, dec_mode, carry_in;
  logic [7:0] acc_in, mem_in;
  logic [7:0] res_out;
  logic       flag_c, flag_z, flag_n, flag_v, res_valid;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  exp_t  exp_q[$];
  string tag_q[$];
  exp_t  last_exp;

  always #2 clk = ~clk;

  bcd_addsub_unit u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .op_sub   (op_sub),
    .dec_mode (dec_mode),
    .carry_in (carry_in),
    .acc_in   (acc_in),
    .mem_in   (mem_in),
    .res_out  (res_out),
    .flag_c   (flag_c),
    .flag_z   (flag_z),
    .flag_n   (flag_n),
    .flag_v   (flag_v),
    .res_valid(res_valid)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, expv);
    end
  endtask

  function automatic exp_t model(input bit sub, input bit dec, input bit cin,
                                 input logic [7:0] a, input logic [7:0] m);
    exp_t e;
    int lo, hi, s, k;
    if (!dec) begin
      if (!sub) begin
        s   = int'(a) + int'(m) + int'(cin);
        e.c = (s > 255);
      end else begin
        s   = int'(a) - int'(m) - 1 + int'(cin);
        e.c = (int'(a) >= int'(m) + 1 - int'(cin));
      end
      e.r = 8'(s);
    end else if (!sub) begin
      lo = int'(a[3:0]) + int'(m[3:0]) + int'(cin);
      k  = 0;
      if (lo >= 10) begin lo -= 10; k = 1; end
      hi = int'(a[7:4]) + int'(m[7:4]) + k;
      e.c = (hi >= 10);
      if (hi >= 10) hi -= 10;
      e.r = {4'(hi), 4'(lo)};
    end else begin
      lo = int'(a[3:0]) - int'(m[3:0]) - 1 + int'(cin);
      k  = 0;
      if (lo < 0) begin lo += 10; k = 1; end
      hi = int'(a[7:4]) - int'(m[7:4]) - k;
      e.c = !(hi < 0);
      if (hi < 0) hi += 10;
      e.r = {4'(hi), 4'(lo)};
    end
    e.z = (e.r == 8'h00);
    e.n = e.r[7];
    if (!sub) e.v = (a[7] == m[7]) && (e.r[7] != a[7]);
    else      e.v = (a[7] != m[7]) && (e.r[7] != a[7]);
    return e;
  endfunction

  // driver: present one operation and push its expected outcome
  task automatic drive(input bit sub, input bit dec, input bit cin,
                       input logic [7:0] a, input logic [7:0] m, input string tag);
    exp_t e;
    @(negedge clk);
    op_valid = 1'b1;
    op_sub   = sub;
    dec_mode = dec;
    carry_in = cin;
    acc_in   = a;
    mem_in   = m;
    e = model(sub, dec, cin, a, m);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    last_exp = e;
  endtask

  task automatic go_idle();
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  // monitor: compare every produced result with the scoreboard head (R10)
  initial begin
    exp_t  e;
    string t;
    forever begin
      @(posedge clk);
      #1;
      if (rst_n === 1'b1 && res_valid === 1'b1) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R10", "unexpected res_valid", 1, 0);
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(res_out == e.r, t, "result", int'(res_out), int'(e.r));
          check(flag_c == e.c, t, "flag_c", int'(flag_c), int'(e.c));
          check(flag_z == e.z && flag_n == e.n, "R7", "z/n",
                int'({flag_z, flag_n}), int'({e.z, e.n}));
          check(flag_v == e.v, (op_sub ? "R9" : "R8"), "flag_v",
                int'(flag_v), int'(e.v));
        end
      end
    end
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n    = 1'b0;
    op_valid = 1'b1;
    op_sub   = 1'b0;
    dec_mode = 1'b0;
    carry_in = 1'b1;
    acc_in   = 8'h7F;
    mem_in   = 8'h7F;
    repeat (3) @(posedge clk);
    #1;
    // R12: outputs cleared while reset is held, despite an active op
    check(res_out == 8'h00, "R12", "res_out in reset", int'(res_out), 0);
    check({flag_c, flag_z, flag_n, flag_v} == 4'h0, "R12", "flags in reset",
          int'({flag_c, flag_z, flag_n, flag_v}), 0);
    check(res_valid == 1'b0, "R12", "res_valid in reset", int'(res_valid), 0);
    @(negedge clk);
    op_valid = 1'b0;
    rst_n    = 1'b1;

    // R1 binary add
    drive(0, 0, 0, 8'hFF, 8'h01, "R1");
    drive(0, 0, 0, 8'h7F, 8'h01, "R1");
    drive(0, 0, 1, 8'h50, 8'h50, "R1");
    drive(0, 0, 1, 8'h12, 8'h34, "R1");
    // R2 binary subtract
    drive(1, 0, 1, 8'h05, 8'h05, "R2");
    drive(1, 0, 0, 8'h05, 8'h05, "R2");
    drive(1, 0, 1, 8'h80, 8'h01, "R2");
    drive(1, 0, 1, 8'h00, 8'h01, "R2");
    drive(1, 0, 0, 8'h06, 8'h05, "R2");
    // R3 decimal add low digit
    drive(0, 1, 0, 8'h09, 8'h01, "R3");
    drive(0, 1, 1, 8'h58, 8'h46, "R3");
    drive(0, 1, 0, 8'h04, 8'h05, "R3");
    // R4 decimal add high digit
    drive(0, 1, 0, 8'h99, 8'h01, "R4");
    drive(0, 1, 0, 8'h50, 8'h50, "R4");
    drive(0, 1, 1, 8'h45, 8'h44, "R4");
    // R5 decimal subtract low digit
    drive(1, 1, 1, 8'h10, 8'h01, "R5");
    drive(1, 1, 0, 8'h20, 8'h00, "R5");
    drive(1, 1, 1, 8'h46, 8'h12, "R5");
    // R6 decimal subtract high digit
    drive(1, 1, 1, 8'h00, 8'h01, "R6");
    drive(1, 1, 1, 8'h12, 8'h21, "R6");
    drive(1, 1, 1, 8'h50, 8'h50, "R6");

    // R11: idle with changing inputs; outputs hold, res_valid drops (R10)
    go_idle();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      acc_in   = 8'(8'h33 + i);
      mem_in   = 8'(8'h91 - i);
      op_sub   = ~op_sub;
      dec_mode = ~dec_mode;
      carry_in = ~carry_in;
    end
    @(posedge clk);
    #1;
    check(res_out == last_exp.r, "R11", "held result", int'(res_out), int'(last_exp.r));
    check({flag_c, flag_z, flag_n, flag_v} ==
          {last_exp.c, last_exp.z, last_exp.n, last_exp.v}, "R11", "held flags",
          int'({flag_c, flag_z, flag_n, flag_v}),
          int'({last_exp.c, last_exp.z, last_exp.n, last_exp.v}));
    check(res_valid == 1'b0, "R10", "res_valid when idle", int'(res_valid), 0);

    // random back-to-back mix, valid decimal digits when in decimal mode
    for (int i = 0; i < 400; i++) begin
      bit sub, dec, cin;
      logic [7:0] a, m;
      sub = 1'($urandom_range(0, 1));
      dec = 1'($urandom_range(0, 1));
      cin = 1'($urandom_range(0, 1));
      if (dec) begin
        a = {4'($urandom_range(0, 9)), 4'($urandom_range(0, 9))};
        m = {4'($urandom_range(0, 9)), 4'($urandom_range(0, 9))};
      end else begin
        a = 8'($urandom_range(0, 255));
        m = 8'($urandom_range(0, 255));
      end
      drive(sub, dec, cin, a, m,
            dec ? (sub ? "R6" : "R4") : (sub ? "R2" : "R1"));
      if (i % 37 == 36) go_idle();
    end
    go_idle();
    repeat (4) @(posedge clk);
    #1;
    check(exp_q.size() == 0, "R10", "scoreboard drained", exp_q.size(), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule